// File: doc/BRIEF.md
# Parallel Configuration Port Master

This block loads a configuration image into a programmable target device through an 8-bit slave parallel port, and it can also read configuration data back out of that device. It drives the program strobe, chip select, write enable, the configuration clock and a tristate data bus. It samples the device's init, busy and done lines. On the upstream side a valid/ready byte stream supplies the image, and a valid-qualified byte output returns readback data. A mode input, a read length and a one-cycle start pulse launch a job. One-cycle ok, fail and abort pulses report how it ended. Every device-side output is a register decoded from the next state, so the pins do not glitch.

The controller is a single enumerated state machine. A half-period pacer sets the configuration clock rate: each clock phase lasts `HALF_CYC` system clocks. A timeout counter guards the three wait phases. Load runs through these states: S_IDLE, then S_PLO (program strobe active), S_PREL (program released, wait for init high and busy low), S_WRA (write enable), S_CSA (chip select), S_CKH (clock high), then the byte loop S_FETCH, S_BLO, S_BHI. S_BHI goes back to S_BLO with the same byte while busy holds, goes to S_FETCH for the next byte, or goes to S_RCS after the last one. S_RCS (chip select released) is followed by S_RWR (write enable released), then the done loop S_DLO and S_DHI, and finally S_OK. Readback runs S_QCS, then the loop S_QLO and S_QHI once per byte, then S_QREL, the trailing S_QTLO and S_QTHI, and S_OK. A timeout in S_PREL, in the busy repeat of S_BHI, or in S_DHI leads to S_FAIL. S_OK and S_FAIL last one cycle each and return to S_IDLE.

Top module: `pcfg_master`

## Requirements
- R1: A load starts with prog_n_o low for exactly HALF_CYC cycles. After that, wr_n_o does not fall until init_n_i is high and busy_i is low.
- R2: If init_n_i high and busy_i low are not both seen within TMO_CYC cycles of the program release, fail_o and abort_o pulse for one cycle. No configuration clock edge then occurs with chip select low, and cs_n_o and wr_n_o end high.
- R3: In a load, wr_n_o falls before cs_n_o falls. dq_oe_o is high only while cs_n_o and wr_n_o are both low.
- R4: Each byte is taken from the stream on ld_valid_i and ld_ready_o, with ld_last_i marking the final byte. The byte is held on dq_o across a low phase and a high phase of cclk_o, each HALF_CYC cycles long. The device sees the bytes in stream order, one rising edge per byte.
- R5: With busy_chk_i = 1, if busy_i is high at the end of a byte's high phase, the same byte is clocked again. This repeats until busy_i is low at that point.
- R6: With busy_chk_i = 0, busy_i is ignored during streaming, and exactly one rising edge occurs per byte.
- R7: If the busy repeat lasts past TMO_CYC cycles, fail_o and abort_o pulse.
- R8: After the last byte, cs_n_o rises HALF_CYC cycles before wr_n_o. cclk_o then toggles until done_i is high, and ok_o pulses. If done_i is already high, no trailing edge occurs.
- R9: If done_i stays low for TMO_CYC cycles of trailing clocks, fail_o and abort_o pulse.
- R10: In readback (mode_rd_i = 1), wr_n_o stays high, dq_oe_o stays low and cs_n_o is low. rd_len_i bytes are read. Each byte is captured from dq_i at the end of the high phase that follows a rising edge, and is presented on rb_data_o with a one-cycle rb_valid_o.
- R11: At the end of readback, cs_n_o rises and then exactly one more low-high cclk_o cycle occurs. With rd_len_i = 0, no byte is read and the trailing cycle still occurs.
- R12: After reset, prog_n_o, cs_n_o, wr_n_o and cclk_o are high. dq_oe_o, ld_ready_o, active_o and all status pulses are low.
- R13: active_o is high from the cycle after start_i until the job ends, and low again once the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle job launch, used only when idle |
| mode_rd_i | input | 1 | 0 selects load, 1 selects readback |
| rd_len_i | input | LEN_W | Number of bytes to read back |
| busy_chk_i | input | 1 | Enables byte repetition on busy during a load |
| ld_data_i | input | DATA_W | Image byte |
| ld_valid_i | input | 1 | Image byte valid |
| ld_last_i | input | 1 | Marks the final image byte |
| ld_ready_o | output | 1 | Block accepts an image byte |
| rb_data_o | output | DATA_W | Readback byte |
| rb_valid_o | output | 1 | Readback byte valid, one cycle |
| active_o | output | 1 | A job is in progress |
| ok_o | output | 1 | Job finished correctly, one cycle |
| fail_o | output | 1 | Job ended on a timeout, one cycle |
| abort_o | output | 1 | Abort pulse to the device side, one cycle |
| prog_n_o | output | 1 | Program strobe, active low |
| cs_n_o | output | 1 | Chip select, active low |
| wr_n_o | output | 1 | Write enable, active low |
| cclk_o | output | 1 | Configuration clock |
| dq_o | output | DATA_W | Data bus out |
| dq_oe_o | output | 1 | Data bus drive enable |
| dq_i | input | DATA_W | Data bus in |
| init_n_i | input | 1 | Device initialising while low |
| busy_i | input | 1 | Device did not take the last byte |
| done_i | input | 1 | Device configured |

## Verification
The assertions assume that reset is applied before the first clock. They also assume the device responds only to configuration clock edges and to the program strobe, and that start_i is a one-cycle pulse given while idle. The bench's device model follows these rules. It changes busy, done and the readback bus only in the half cycle after a sampled clock edge, and changes init only in response to the program strobe. The upstream stream presents each byte with ld_last_i on the final one and may insert random gaps in valid. Stalls, done delays and lengths are drawn from a seeded generator within these limits, and stuck-line cases are added by hand.

// File: rtl/pcfg_pkg.sv
`timescale 1ns/1ps
package pcfg_pkg;

    typedef enum logic [4:0] {
        S_IDLE, S_PLO, S_PREL, S_WRA, S_CSA, S_CKH, S_FETCH, S_BLO, S_BHI,
        S_RCS, S_RWR, S_DLO, S_DHI, S_QCS, S_QLO, S_QHI, S_QREL, S_QTLO,
        S_QTHI, S_OK, S_FAIL
    } pcfg_state_e;

    typedef struct packed {
        logic prog_n;
        logic cs_n;
        logic wr_n;
        logic cclk;
        logic oe;
    } pcfg_pins_t;

    // Pin levels held in each state; idle level is all strobes high.
    function automatic pcfg_pins_t pcfg_pin_map(pcfg_state_e s);
        pcfg_pins_t p;
        p = '{prog_n: 1'b1, cs_n: 1'b1, wr_n: 1'b1, cclk: 1'b1, oe: 1'b0};
        case (s)
            S_PLO:  p.prog_n = 1'b0;
            S_WRA, S_RCS: p.wr_n = 1'b0;
            S_CSA, S_CKH, S_FETCH, S_BHI: begin
                p.wr_n = 1'b0; p.cs_n = 1'b0; p.oe = 1'b1;
            end
            S_BLO: begin
                p.wr_n = 1'b0; p.cs_n = 1'b0; p.oe = 1'b1; p.cclk = 1'b0;
            end
            S_DLO, S_QTLO: p.cclk = 1'b0;
            S_QCS, S_QHI:  p.cs_n = 1'b0;
            S_QLO: begin
                p.cs_n = 1'b0; p.cclk = 1'b0;
            end
            default: ;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/pcfg_pacer.sv
`timescale 1ns/1ps
module pcfg_pacer #(
    parameter int HALF_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic expire
);
    localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

    logic [CW-1:0] cnt_q;

    assign expire = (cnt_q == CW'(HALF_CYC - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt_q <= '0;
        else if (restart) cnt_q <= '0;
        else if (!expire) cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/pcfg_timer.sv
`timescale 1ns/1ps
module pcfg_timer #(
    parameter int TMO_CYC = 2_500_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int TW = $clog2(TMO_CYC + 1);

    logic [TW-1:0] cnt_q;

    assign expired = (cnt_q >= TW'(TMO_CYC - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cnt_q <= '0;
        else if (!run)     cnt_q <= '0;
        else if (!expired) cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/pcfg_master.sv
`timescale 1ns/1ps
module pcfg_master
    import pcfg_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int LEN_W    = 16,
    parameter int HALF_CYC = 3,
    parameter int TMO_CYC  = 2_500_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              mode_rd_i,
    input  logic [LEN_W-1:0]  rd_len_i,
    input  logic              busy_chk_i,
    input  logic [DATA_W-1:0] ld_data_i,
    input  logic              ld_valid_i,
    input  logic              ld_last_i,
    output logic              ld_ready_o,
    output logic [DATA_W-1:0] rb_data_o,
    output logic              rb_valid_o,
    output logic              active_o,
    output logic              ok_o,
    output logic              fail_o,
    output logic              abort_o,
    output logic              prog_n_o,
    output logic              cs_n_o,
    output logic              wr_n_o,
    output logic              cclk_o,
    output logic [DATA_W-1:0] dq_o,
    output logic              dq_oe_o,
    input  logic [DATA_W-1:0] dq_i,
    input  logic              init_n_i,
    input  logic              busy_i,
    input  logic              done_i
);
    pcfg_state_e       state_q, nstate;
    pcfg_pins_t        pins_q;
    logic [DATA_W-1:0] byte_q;
    logic [LEN_W-1:0]  len_q, idx_q;
    logic              last_q, rd_q, bwait_q;
    logic              half, tmo, tmo_run;

    // Phase pacer restarts on every state change.
    pcfg_pacer #(.HALF_CYC(HALF_CYC)) u_pacer (
        .clk(clk), .rst_n(rst_n), .restart(nstate != state_q), .expire(half)
    );

    // Timeout runs only in the three wait phases.
    assign tmo_run = (state_q == S_PREL) || (state_q == S_DLO) ||
                     (state_q == S_DHI)  || bwait_q;

    pcfg_timer #(.TMO_CYC(TMO_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(tmo_run), .expired(tmo)
    );

    always_comb begin
        nstate = state_q;
        unique case (state_q)
            S_IDLE:  if (start_i) nstate = mode_rd_i ? S_QCS : S_PLO;
            S_PLO:   if (half) nstate = S_PREL;
            S_PREL:  if (init_n_i && !busy_i) nstate = S_WRA;
                     else if (tmo)            nstate = S_FAIL;
            S_WRA:   if (half) nstate = S_CSA;
            S_CSA:   if (half) nstate = S_CKH;
            S_CKH:   if (half) nstate = S_FETCH;
            S_FETCH: if (ld_valid_i) nstate = S_BLO;
            S_BLO:   if (half) nstate = S_BHI;
            S_BHI:   if (half) begin
                         if (busy_chk_i && busy_i)
                             nstate = (bwait_q && tmo) ? S_FAIL : S_BLO;
                         else
                             nstate = last_q ? S_RCS : S_FETCH;
                     end
            S_RCS:   if (half) nstate = S_RWR;
            S_RWR:   if (half) nstate = done_i ? S_OK : S_DLO;
            S_DLO:   if (half) nstate = S_DHI;
            S_DHI:   if (half) nstate = done_i ? S_OK : (tmo ? S_FAIL : S_DLO);
            S_QCS:   if (half) nstate = (len_q == '0) ? S_QREL : S_QLO;
            S_QLO:   if (half) nstate = S_QHI;
            S_QHI:   if (half) nstate = (idx_q == len_q - 1'b1) ? S_QREL : S_QLO;
            S_QREL:  if (half) nstate = S_QTLO;
            S_QTLO:  if (half) nstate = S_QTHI;
            S_QTHI:  if (half) nstate = S_OK;
            S_OK, S_FAIL: nstate = S_IDLE;
            default: nstate = S_IDLE;
        endcase
    end

    // State register with the job context it carries.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            byte_q  <= '0;
            len_q   <= '0;
            idx_q   <= '0;
            last_q  <= 1'b0;
            rd_q    <= 1'b0;
            bwait_q <= 1'b0;
        end else begin
            state_q <= nstate;
            case (state_q)
                S_IDLE: begin
                    bwait_q <= 1'b0;
                    if (start_i) begin
                        rd_q  <= mode_rd_i;
                        len_q <= rd_len_i;
                        idx_q <= '0;
                    end
                end
                S_FETCH: if (ld_valid_i) begin
                    byte_q <= ld_data_i;
                    last_q <= ld_last_i;
                end
                S_BHI: if (half) bwait_q <= busy_chk_i && busy_i;
                S_QHI: if (half) idx_q <= idx_q + 1'b1;
                default: ;
            endcase
        end
    end

    // Registered outputs decoded from the next state.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pins_q     <= pcfg_pin_map(S_IDLE);
            ok_o       <= 1'b0;
            fail_o     <= 1'b0;
            abort_o    <= 1'b0;
            active_o   <= 1'b0;
            rb_valid_o <= 1'b0;
            rb_data_o  <= '0;
        end else begin
            pins_q     <= pcfg_pin_map(nstate);
            ok_o       <= (nstate == S_OK);
            fail_o     <= (nstate == S_FAIL);
            abort_o    <= (nstate == S_FAIL);
            active_o   <= (nstate != S_IDLE);
            rb_valid_o <= (state_q == S_QHI) && half;
            if ((state_q == S_QHI) && half) rb_data_o <= dq_i;
        end
    end

    assign prog_n_o   = pins_q.prog_n;
    assign cs_n_o     = pins_q.cs_n;
    assign wr_n_o     = pins_q.wr_n;
    assign cclk_o     = pins_q.cclk;
    assign dq_oe_o    = pins_q.oe;
    assign dq_o       = byte_q;
    assign ld_ready_o = (state_q == S_FETCH);

    // R3: the bus is driven only under both strobes
    p_oe_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe_o |-> (!cs_n_o && !wr_n_o));
    // R3: in a load, chip select falls only with write enable already low
    p_wr_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n_o) |-> (!wr_n_o || rd_q));
    // R8: write enable never rises while chip select is still low
    p_cs_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_n_o) |-> cs_n_o);
    // R4: data is steady across each rising edge it is clocked on
    p_bus_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe_o && $rose(cclk_o)) |-> $stable(dq_o));
    // R2: abort is a single-cycle pulse
    p_abort_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |=> !abort_o);
    // R10: readback never drives the bus
    p_rb_hiz_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_q && !cs_n_o) |-> (!dq_oe_o && wr_n_o));
    // R1: program strobe only with the port otherwise released
    p_prog_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_n_o |-> (cs_n_o && wr_n_o && !dq_oe_o));
endmodule

// File: tb/pcfg_master_bench.sv
`timescale 1ns/1ps
module pcfg_master_bench;
    localparam int HALF = 3;
    localparam int TMO  = 400;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic       start = 0, mode_rd = 0, busy_chk = 1;
    logic [15:0] rd_len = 0;
    logic [7:0] ld_data = 0;
    logic       ld_valid = 0, ld_last = 0, ld_ready;
    logic [7:0] rb_data;
    logic       rb_valid, active, ok, fail, abort_s;
    logic       prog_n, cs_n, wr_n, cclk, dq_oe;
    logic [7:0] dq_o, dq_i = 0;
    logic       init_n = 1, dbusy = 0, done = 0;

    pcfg_master #(.HALF_CYC(HALF), .TMO_CYC(TMO)) u_pcfg_master (
        .clk(clk), .rst_n(rst_n), .start_i(start), .mode_rd_i(mode_rd),
        .rd_len_i(rd_len), .busy_chk_i(busy_chk), .ld_data_i(ld_data),
        .ld_valid_i(ld_valid), .ld_last_i(ld_last), .ld_ready_o(ld_ready),
        .rb_data_o(rb_data), .rb_valid_o(rb_valid), .active_o(active),
        .ok_o(ok), .fail_o(fail), .abort_o(abort_s), .prog_n_o(prog_n),
        .cs_n_o(cs_n), .wr_n_o(wr_n), .cclk_o(cclk), .dq_o(dq_o),
        .dq_oe_o(dq_oe), .dq_i(dq_i), .init_n_i(init_n), .busy_i(dbusy),
        .done_i(done)
    );

    int total = 0, bad = 0, cyc = 0;
    logic [7:0] tx [0:31];
    logic [7:0] rx [0:31];
    int n_ld = 0, idx = 0;
    int init_delay = 10, init_stuck = 0, pre_busy = 0, init_cnt = 0, pre_cnt = 0;
    int stall_at = 0, stall_n = 0, stall_left = 0, done_after = 0, done_never = 0;
    int cfg_rb = 0, got = 0, ld_edges = 0, trail = 0, prog_w = 0;
    int order_bad = 0, pre_bad = 0, lo_run = 0, lo_min = 999, lo_max = 0;
    int rb_k = 0, rb_got = 0, rb_err = 0, rb_trail = 0, oe_rb = 0;
    int ok_seen = 0, fail_seen = 0, abort_seen = 0;
    logic prev_cclk = 1, prev_cs = 1, prev_wr = 1, xfer_q = 0;

    function automatic logic [7:0] pat(int k);
        return 8'(k * 29 + 7) ^ 8'h5a;
    endfunction

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    always @(posedge clk) begin
        xfer_q <= ld_valid && ld_ready;
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            summary();
            $finish;
        end
    end

    // Device model and monitors, all at the falling edge.
    always @(negedge clk) if (rst_n) begin
        logic rise;
        if (prev_wr && !wr_n && (!init_n || dbusy)) pre_bad++;
        if (!prev_wr && wr_n && !cs_n) order_bad++;
        if (prev_cs && !cs_n && !cfg_rb && wr_n) order_bad++;
        rise = cclk && !prev_cclk;
        if (!cclk && !cs_n && !wr_n) lo_run++;
        else if (lo_run > 0) begin
            if (lo_run < lo_min) lo_min = lo_run;
            if (lo_run > lo_max) lo_max = lo_run;
            lo_run = 0;
        end
        if (!prog_n) begin
            init_n = 0; init_cnt = 0; done = 0; dbusy = 0; prog_w++;
        end else if (!init_n) begin
            if (init_stuck == 0) begin
                init_cnt++;
                if (init_cnt >= init_delay) begin
                    init_n = 1; pre_cnt = pre_busy; dbusy = (pre_busy > 0);
                end
            end
        end else if (pre_cnt > 0) begin
            pre_cnt--;
            if (pre_cnt == 0) dbusy = 0;
        end
        if (rise && !cs_n && !wr_n) begin
            ld_edges++;
            if (stall_left > 0 && got == stall_at) begin
                stall_left--; dbusy = 1;
            end else begin
                dbusy = 0;
                if (got < 32) rx[got] = dq_o;
                got++;
                if (got == n_ld && done_after == 0 && done_never == 0) done = 1;
            end
        end else if (rise && cs_n && wr_n && cfg_rb == 0) begin
            trail++;
            if (trail >= done_after && done_never == 0) done = 1;
        end
        if (rise && cfg_rb != 0) begin
            if (!cs_n) begin dq_i = pat(rb_k); rb_k++; end
            else rb_trail++;
        end
        if (cfg_rb != 0 && dq_oe) oe_rb++;
        if (rb_valid) begin
            if (rb_data !== pat(rb_got)) rb_err++;
            rb_got++;
        end
        if (ok) ok_seen++;
        if (fail) fail_seen++;
        if (abort_s) abort_seen++;
        if (xfer_q) idx++;
        ld_valid = (idx < n_ld) && (($urandom % 4) != 0);
        ld_data  = tx[(idx < 32) ? idx : 0];
        ld_last  = (idx == n_ld - 1);
        prev_cclk = cclk; prev_cs = cs_n; prev_wr = wr_n;
    end

    task automatic clear_model();
        got = 0; ld_edges = 0; trail = 0; prog_w = 0; order_bad = 0; pre_bad = 0;
        lo_run = 0; lo_min = 999; lo_max = 0; rb_k = 0; rb_got = 0; rb_err = 0;
        rb_trail = 0; oe_rb = 0; ok_seen = 0; fail_seen = 0; abort_seen = 0; idx = 0;
    endtask

    task automatic launch(string tag);
        start = 1;
        @(negedge clk); #1;
        start = 0;
        chk({tag, " R13 active after start"}, int'(active), 1);
        do begin @(negedge clk); #1; end while (ok_seen == 0 && fail_seen == 0);
        repeat (4) @(negedge clk);
        #1;
        chk({tag, " R13 idle after end"}, int'(active), 0);
    endtask

    task automatic run_load(int n, logic chk_en, int s_at, int s_n, int d_after,
                            int d_never, int i_stuck, int p_busy);
        @(negedge clk); #1;
        clear_model();
        for (int i = 0; i < n; i++) tx[i] = 8'($urandom);
        n_ld = n; cfg_rb = 0; mode_rd = 0; busy_chk = chk_en;
        stall_at = s_at; stall_n = s_n; stall_left = s_n;
        done_after = d_after; done_never = d_never;
        init_stuck = i_stuck; pre_busy = p_busy; init_delay = 10;
        launch("load");
    endtask

    task automatic check_good_load(string tag, int n, int extra, int d_after);
        int mism = 0;
        for (int i = 0; i < n; i++) if (rx[i] !== tx[i]) mism++;
        chk({tag, " R4 byte mismatches"}, mism, 0);
        chk({tag, " R4 bytes taken"}, got, n);
        chk({tag, " R5 rising edges"}, ld_edges, n + extra);
        chk({tag, " R4 low phase min"}, lo_min, HALF);
        chk({tag, " R4 low phase max"}, lo_max, HALF);
        chk({tag, " R1 program width"}, prog_w, HALF);
        chk({tag, " R1 write before init/busy"}, pre_bad, 0);
        chk({tag, " R3 R8 strobe order"}, order_bad, 0);
        chk({tag, " R8 trailing edges"}, trail, d_after);
        chk({tag, " R8 ok pulse"}, ok_seen, 1);
        chk({tag, " R8 no abort"}, abort_seen, 0);
    endtask

    task automatic run_rb(int len);
        @(negedge clk); #1;
        clear_model();
        cfg_rb = 1; n_ld = 0; mode_rd = 1; rd_len = 16'(len);
        launch("readback");
        chk("R10 bytes read", rb_got, len);
        chk("R10 byte values", rb_err, 0);
        chk("R10 bus undriven", oe_rb, 0);
        chk("R11 trailing edge", rb_trail, 1);
        chk("R10 ok pulse", ok_seen, 1);
        chk("R10 no program strobe", prog_w, 0);
    endtask

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        #1;
        chk("R12 prog_n reset", int'(prog_n), 1);
        chk("R12 cs_n reset", int'(cs_n), 1);
        chk("R12 wr_n reset", int'(wr_n), 1);
        chk("R12 cclk reset", int'(cclk), 1);
        chk("R12 oe reset", int'(dq_oe), 0);
        chk("R12 status reset", int'({ld_ready, active, ok, fail, abort_s}), 0);
        rst_n = 1;
        repeat (2) @(negedge clk);

        run_load(8, 1, 0, 0, 2, 0, 0, 0);
        check_good_load("basic", 8, 0, 2);

        run_load(7, 1, 3, 4, 1, 0, 0, 0);   // R5 repeated byte
        check_good_load("stall", 7, 4, 1);

        run_load(6, 0, 1, 2, 1, 0, 0, 0);   // R6 busy ignored
        chk("R6 one edge per byte", ld_edges, 6);
        chk("R6 ok pulse", ok_seen, 1);

        run_load(5, 1, 0, 0, 0, 0, 0, 30);  // R1 busy after init, R8 done early
        check_good_load("early done", 5, 0, 0);

        run_load(4, 1, 0, 0, 0, 0, 1, 0);   // R2 init stuck
        chk("R2 fail pulse", fail_seen, 1);
        chk("R2 abort pulse", abort_seen, 1);
        chk("R2 no data edges", ld_edges, 0);
        chk("R2 strobes released", int'(cs_n && wr_n), 1);
        chk("R2 no ok", ok_seen, 0);

        run_load(6, 1, 2, 100000, 0, 0, 0, 0);  // R7 busy stuck
        chk("R7 fail pulse", fail_seen, 1);
        chk("R7 abort pulse", abort_seen, 1);
        chk("R7 bytes before stall", got, 2);
        chk("R7 strobes released", int'(cs_n && wr_n), 1);

        run_load(3, 1, 0, 0, 0, 1, 0, 0);   // R9 done never
        chk("R9 fail pulse", fail_seen, 1);
        chk("R9 abort pulse", abort_seen, 1);
        chk("R9 trailing edges seen", int'(trail > 0), 1);
        chk("R9 bytes delivered", got, 3);

        run_rb(9);
        run_rb(0);

        for (int it = 0; it < 5; it++) begin
            int n, sa, sn, da;
            n  = 1 + int'($urandom % 16);
            sa = int'($urandom % n);
            sn = int'($urandom % 4);
            da = int'($urandom % 4);
            run_load(n, 1, sa, sn, da, 0, 0, 0);
            check_good_load("random", n, sn, da);
            run_rb(1 + int'($urandom % 12));
        end

        summary();
        $finish;
    end
endmodule